// File: doc/BRIEF.md
# 4x4 Integer Inverse Transform

This block turns a 4x4 block of signed dequantized coefficients into a 4x4 block of signed 16-bit residuals. It runs a separable two-pass inverse transform. The first pass runs down each column and the second along each row. Each pass uses two fixed-point rotation multipliers in Q16. Every sum and difference is clamped to the signed 16-bit range. The final values are rounded and divided by eight after the row pass and at no earlier point.

A whole block of sixteen coefficients arrives in one transfer on a valid/ready input. That input is ready only while the block is idle. The input is back-pressured from the cycle a block is accepted until the last output row has been taken. The four result rows leave in order, 0 to 3, on a valid/ready output. The consumer may hold `out_ready` low for any number of cycles. While it does, the row on offer and its index stay unchanged. A one-cycle `done` pulse follows the last row. The consumer places rows into its frame buffer and performs the prediction add.

Top module: `idct4x4_inv`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1 and `out_valid` and `done` are 0.
- R2: A block is taken only on a cycle with `in_valid` and `in_ready` both high. After that, `in_ready` stays 0 until the last row has been taken, and any `in_valid` or data offered meanwhile has no effect on the results. Coefficient (row r, column c) sits at bits [16*(4r+c) +: 16] of `in_coef`.
- R3: Each 1-D pass maps inputs x0..x3 as follows: a1 = x0+x2, b1 = x0-x2, c1 = S(x1) - (x3 + C(x3)), d1 = (x1 + C(x1)) + S(x3). The outputs are y0 = a1+d1, y1 = b1+c1, y2 = b1-c1 and y3 = a1-d1.
- R4: C(x) = floor(x*20091/65536) and S(x) = floor(x*35468/65536). S is formed as a signed multiply by 35468-65536, then x is added back. No rounding is applied inside either pass.
- R5: The column pass runs first, over coefficients (0..3, c). The row pass then runs over the column results (r, 0..3).
- R6: Every add and subtract in both passes saturates to [-32768, 32767].
- R7: Each value after the row pass becomes (v+4)>>>3, computed without overflow. For example, 3 gives 0, 4 gives 1, -4 gives 0 and -5 gives -1.
- R8: Output rows appear with `out_row_idx` equal to 0, 1, 2 and 3, in that order. Result (r, c) sits at bits [16*c +: 16] of `out_row_data`. While `out_valid` is high and `out_ready` is low, both the data and the index hold steady.
- R9: `done` is high for exactly the one cycle after the handshake of row 3. `in_ready` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient block offered |
| in_ready | output | 1 | Block can be taken (idle) |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients, row-major |
| out_valid | output | 1 | Result row offered |
| out_ready | input | 1 | Consumer takes the row |
| out_row_data | output | 64 | Four signed 16-bit residuals of one row |
| out_row_idx | output | 2 | Index of the row on offer |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
The protocol properties assume one thing about the inputs: reset is asserted before the first block. They place no limit on `out_ready` or on the coefficient values. Any stall pattern and any 16-bit lane content must leave the output handshake rules intact. The stimulus mostly draws coefficients from the stated 13-bit range. A dedicated block of extreme 16-bit values drives the saturation paths. The stall patterns hold `out_ready` low for two cycles out of three, so every row spends time waiting. One scenario keeps `in_valid` high with unrelated data throughout the busy period, to show it is ignored.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COL  = 2'd1,
    ST_ROW  = 2'd2,
    ST_OUT  = 2'd3
  } idct_state_t;

  localparam int K_COS_Q16 = 20091;
  localparam int K_SIN_Q16 = 35468;
endpackage

// File: rtl/idct4_butterfly.sv
module idct4_butterfly #(
  parameter int DW  = 16,
  parameter int K_C = 20091,
  parameter int K_S = 35468
) (
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  input  logic signed [DW-1:0] x3,
  output logic signed [DW-1:0] y0,
  output logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y2,
  output logic signed [DW-1:0] y3
);
  localparam logic signed [DW-1:0] MAXS = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINS = {1'b1, {(DW-1){1'b0}}};
  localparam bit S_WRAPS = (K_S > ((1 << (DW-1)) - 1));
  localparam logic [DW-1:0] KC_BITS = K_C[DW-1:0];
  localparam logic [DW-1:0] KS_BITS = K_S[DW-1:0];

  function automatic logic signed [DW-1:0] clamp(input logic signed [DW:0] v);
    if (v > MAXS) return MAXS;
    else if (v < MINS) return MINS;
    else return v[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] sadd(input logic signed [DW-1:0] a,
                                               input logic signed [DW-1:0] b);
    logic signed [DW:0] s;
    s = $signed({a[DW-1], a}) + $signed({b[DW-1], b});
    return clamp(s);
  endfunction

  function automatic logic signed [DW-1:0] ssub(input logic signed [DW-1:0] a,
                                               input logic signed [DW-1:0] b);
    logic signed [DW:0] s;
    s = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
    return clamp(s);
  endfunction

  // high half of a signed DW x DW product: floor(x*k / 2^DW)
  function automatic logic signed [DW-1:0] mulhi(input logic signed [DW-1:0] x,
                                                input logic [DW-1:0] k);
    logic signed [2*DW-1:0] xe, ke, p;
    xe = $signed({{DW{x[DW-1]}}, x});
    ke = $signed({{DW{k[DW-1]}}, k});
    p  = xe * ke;
    return p[2*DW-1:DW];
  endfunction

  // cosine branch: constant is (factor - 1), so the input is always added
  function automatic logic signed [DW-1:0] cos_t(input logic signed [DW-1:0] x);
    return sadd(x, mulhi(x, KC_BITS));
  endfunction

  // sine branch: a constant above the signed range is wrapped negative, input added back
  function automatic logic signed [DW-1:0] sin_t(input logic signed [DW-1:0] x);
    if (S_WRAPS) return sadd(mulhi(x, KS_BITS), x);
    else return mulhi(x, KS_BITS);
  endfunction

  logic signed [DW-1:0] a1, b1, c1, d1;

  always_comb begin
    a1 = sadd(x0, x2);
    b1 = ssub(x0, x2);
    c1 = ssub(sin_t(x1), cos_t(x3));
    d1 = sadd(cos_t(x1), sin_t(x3));
    y0 = sadd(a1, d1);
    y1 = sadd(b1, c1);
    y2 = ssub(b1, c1);
    y3 = ssub(a1, d1);
  end
endmodule

// File: rtl/idct4_round.sv
module idct4_round #(
  parameter int DW    = 16,
  parameter int SHIFT = 3
) (
  input  logic signed [DW-1:0] v,
  output logic signed [DW-1:0] r
);
  localparam logic signed [DW:0] RND = (DW+1)'(1) << (SHIFT-1);
  logic signed [DW:0] t;

  always_comb begin
    t = $signed({v[DW-1], v}) + RND;
    r = {{(SHIFT-1){t[DW]}}, t[DW:SHIFT]};
  end
endmodule

// File: rtl/idct4x4_inv.sv
module idct4x4_inv
  import idct4_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SHIFT = 3,
  parameter int K_C   = K_COS_Q16,
  parameter int K_S   = K_SIN_Q16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [16*DW-1:0]     in_coef,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [4*DW-1:0]      out_row_data,
  output logic [1:0]           out_row_idx,
  output logic                 done
);
  localparam int N  = 4;
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N-1);

  idct_state_t state;
  logic [IW-1:0] row_q;
  logic done_q;

  // one block store: coefficients, then column results, then final residuals
  logic signed [DW-1:0] buf_q  [N][N];
  logic signed [DW-1:0] colres [N][N];
  logic signed [DW-1:0] rowres [N][N];
  logic signed [DW-1:0] rnd    [N][N];

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_col
      idct4_butterfly #(.DW(DW), .K_C(K_C), .K_S(K_S)) i_col (
        .x0(buf_q[0][gi]), .x1(buf_q[1][gi]), .x2(buf_q[2][gi]), .x3(buf_q[3][gi]),
        .y0(colres[0][gi]), .y1(colres[1][gi]), .y2(colres[2][gi]), .y3(colres[3][gi])
      );
    end
    for (gi = 0; gi < N; gi++) begin : g_row
      idct4_butterfly #(.DW(DW), .K_C(K_C), .K_S(K_S)) i_row (
        .x0(buf_q[gi][0]), .x1(buf_q[gi][1]), .x2(buf_q[gi][2]), .x3(buf_q[gi][3]),
        .y0(rowres[gi][0]), .y1(rowres[gi][1]), .y2(rowres[gi][2]), .y3(rowres[gi][3])
      );
      for (gj = 0; gj < N; gj++) begin : g_rnd
        idct4_round #(.DW(DW), .SHIFT(SHIFT)) i_rnd (
          .v(rowres[gi][gj]), .r(rnd[gi][gj])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      row_q  <= '0;
      done_q <= 1'b0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          buf_q[r][c] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (in_valid) begin
          for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
              buf_q[r][c] <= in_coef[(r*N+c)*DW +: DW];
          state <= ST_COL;
        end
        ST_COL: begin
          buf_q <= colres;
          state <= ST_ROW;
        end
        ST_ROW: begin
          buf_q <= rnd;
          row_q <= '0;
          state <= ST_OUT;
        end
        default: if (out_ready) begin
          if (row_q == LAST) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++)
      out_row_data[c*DW +: DW] = buf_q[row_q][c];
  end

  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_OUT);
  assign out_row_idx = row_q;
  assign done        = done_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_row_data) && $stable(out_row_idx));
  p_order_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_row_idx != LAST |=> out_valid && out_row_idx == $past(out_row_idx) + 1'b1);
  p_first_row_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_row_idx == '0);
  p_busy_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready && out_row_idx == LAST) && in_ready);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/test_idct4x4_inv.sv
module test_idct4x4_inv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [255:0] in_coef = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [63:0] out_row_data;
  logic [1:0] out_row_idx;
  logic done;

  int checks = 0;
  int errors = 0;
  int got [4][4];

  always #10 clk = ~clk;

  idct4x4_inv i_idct4x4_inv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
    .out_valid(out_valid), .out_ready(out_ready), .out_row_data(out_row_data),
    .out_row_idx(out_row_idx), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int qmul(input int x, input int k);
    return (x * k) >>> 16;
  endfunction

  task automatic ref1d(input int x0, input int x1, input int x2, input int x3,
                       output int y0, output int y1, output int y2, output int y3);
    int a, b, c, d;
    a = sat16(x0 + x2);
    b = sat16(x0 - x2);
    c = sat16(qmul(x1, 35468) - sat16(x3 + qmul(x3, 20091)));
    d = sat16(sat16(x1 + qmul(x1, 20091)) + qmul(x3, 35468));
    y0 = sat16(a + d); y1 = sat16(b + c); y2 = sat16(b - c); y3 = sat16(a - d);
  endtask

  task automatic ref2d(input int m [4][4], output int e [4][4]);
    int t [4][4];
    for (int c = 0; c < 4; c++)
      ref1d(m[0][c], m[1][c], m[2][c], m[3][c], t[0][c], t[1][c], t[2][c], t[3][c]);
    for (int r = 0; r < 4; r++)
      ref1d(t[r][0], t[r][1], t[r][2], t[r][3], e[r][0], e[r][1], e[r][2], e[r][3]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        e[r][c] = (e[r][c] + 4) >>> 3;
  endtask

  // stall: 0 = always ready, 1 = ready one cycle in three; poke: keep offering junk while busy
  task automatic run_block(input int m [4][4], input int stall, input bit poke, input string tag);
    int e [4][4];
    int r = 0;
    int cyc = 0;
    bit pend = 0;
    logic [63:0] held;
    logic [63:0] expw;
    ref2d(m, e);
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "in_ready before transfer", int'(in_ready), 1);
    in_valid = 1'b1;
    for (int rr = 0; rr < 4; rr++)
      for (int c = 0; c < 4; c++)
        in_coef[(rr*4+c)*16 +: 16] = 16'(m[rr][c]);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2", "in_ready after transfer", int'(in_ready), 0);
    if (poke) in_coef = {8{32'h7fff8001}};
    else in_valid = 1'b0;
    while (r < 4 && cyc < 2000) begin
      if (pend)
        chk(out_valid && out_row_data == held, "R8", "row held under stall", int'(out_row_data[15:0]), int'(held[15:0]));
      pend = 0;
      out_ready = (stall == 0) ? 1'b1 : (cyc % 3 == 2);
      if (out_valid) begin
        chk(in_ready == 1'b0, "R2", "in_ready while rows pending", int'(in_ready), 0);
        if (out_ready) begin
          for (int c = 0; c < 4; c++) expw[c*16 +: 16] = 16'(e[r][c]);
          chk(out_row_idx == 2'(r), "R8", "row index order", int'(out_row_idx), r);
          chk(out_row_data == expw, tag, $sformatf("row %0d data", r), int'($signed(out_row_data[15:0])), e[r][0]);
          for (int c = 0; c < 4; c++) got[r][c] = int'($signed(out_row_data[c*16 +: 16]));
          r++;
        end else begin
          pend = 1;
          held = out_row_data;
        end
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    chk(r == 4, "R8", "all rows delivered", r, 4);
    chk(done == 1'b1, "R9", "done after last row", int'(done), 1);
    chk(in_ready == 1'b1, "R9", "in_ready with done", int'(in_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_round();
    int vals [8] = '{3, 4, -4, -5, 12, -12, 4095, -4096};
    int expv [8] = '{0, 1, 0, -1, 2, -1, 512, -512};
    for (int k = 0; k < 8; k++) begin
      int m [4][4];
      for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = 0;
      m[0][0] = vals[k];
      run_block(m, 0, 0, "R7 R3");
      chk(got[3][3] == expv[k], "R7", $sformatf("dc %0d rounding", vals[k]), got[3][3], expv[k]);
    end
  endtask

  task automatic t_single();
    for (int p = 1; p < 16; p += 3) begin
      int m [4][4];
      for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = 0;
      m[p/4][p%4] = (p % 2 == 0) ? 3001 : -2777;
      run_block(m, 0, 0, "R4 R5");
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 16; k++) begin
      int m [4][4];
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          m[r][c] = int'($urandom_range(8191, 0)) - 4096;
      run_block(m, k % 2, 0, "R3 R4 R5");
    end
  endtask

  task automatic t_saturate();
    int m [4][4];
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = 32767;
    run_block(m, 0, 0, "R6");
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = ((r + c) % 2) ? -32768 : 32767;
    run_block(m, 1, 0, "R6");
  endtask

  task automatic t_busy_poke();
    int m [4][4];
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = (r * 4 + c) * 97 - 700;
    run_block(m, 1, 1, "R2");
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m[r][c] = 0;
    run_block(m, 0, 0, "R2");
    chk(got[0][0] == 0, "R2", "no stray block accepted", got[0][0], 0);
  endtask

  initial begin
    t_reset();
    t_round();
    t_single();
    t_random();
    t_saturate();
    t_busy_poke();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule